// File: doc/BRIEF.md
# Serial Receiver with Ready-to-Send Output

This block receives asynchronous 8N1 serial frames (one low start bit, eight data bits least significant first, one high stop bit). It oversamples the line with a baud tick that pulses sixteen times per bit period, and places each good byte into local storage. A consumer takes bytes through a valid/ready read port.

Storage has two modes, chosen by `fifo_mode_i`. In single-register mode it holds one byte. In queue mode it holds up to `DEPTH` bytes in arrival order.

The active-low `rts_n_o` output tells the far-end transmitter whether it may send more. When flow control is enabled, the output is low while storage can take another byte and high once storage is at capacity. Capacity means one byte in single-register mode and `DEPTH` bytes in queue mode. Raising `rts_n_o` does not affect the receiver: a frame already on the line is still taken in completely.

Top module: `uart_rx_rts`

## Requirements
- R1: While `rts_en_i` is 0, `rts_n_o` is 0 whatever the storage holds.
- R2: While `rts_en_i` is 1 and storage is below capacity, `rts_n_o` is 0.
- R3: In single-register mode (`fifo_mode_i`=0) with `rts_en_i`=1, `rts_n_o` is 1 from the clock after a byte is stored, for as long as that byte is unread; `rx_not_empty_o` is 1 at the same time.
- R4: In queue mode (`fifo_mode_i`=1) with `rts_en_i`=1, `rts_n_o` stays 0 while 1 to DEPTH-1 bytes are held and is 1 only when DEPTH bytes are held.
- R5: A read (`rd_valid_o` and `rd_ready_i` both 1 at a clock edge) removes the oldest byte. If the byte count then falls below capacity, `rts_n_o` is 0 from that edge on. When the last byte is removed, `rd_valid_o` and `rx_not_empty_o` fall to 0.
- R6: The line passes through two synchronizing flops. A start bit is accepted only if the line is still low on the eighth tick after the falling edge is seen; a shorter low pulse is ignored. Each later bit is sampled sixteen ticks after the previous sample, data least significant bit first.
- R7: Reception does not depend on `rts_n_o`: a frame that is in progress when `rts_n_o` rises is still received and stored, provided storage has room when its stop bit is sampled.
- R8: A good frame that ends while storage is at capacity (judged before any read in that cycle) is dropped, and stored bytes are unchanged. `overrun_o` pulses high for one clock in the following cycle.
- R9: A frame whose stop bit is sampled low is dropped, and `frame_err_o` pulses high for one clock in the following cycle.
- R10: In queue mode bytes leave in arrival order. A store and a read in the same cycle both take effect.
- R11: After reset, `rd_valid_o`, `rx_not_empty_o`, `overrun_o`, `frame_err_o` and `rts_n_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line, idle high |
| tick_i | input | 1 | Oversampling tick, 16 per bit period |
| rts_en_i | input | 1 | Enables ready-to-send flow control |
| fifo_mode_i | input | 1 | 0: single register, 1: queue of DEPTH bytes |
| rd_data_o | output | DATA_W | Oldest stored byte |
| rd_valid_o | output | 1 | A byte is available |
| rd_ready_i | input | 1 | Consumer takes the byte |
| rx_not_empty_o | output | 1 | Storage holds at least one byte |
| overrun_o | output | 1 | One-cycle pulse: byte dropped, storage at capacity |
| frame_err_o | output | 1 | One-cycle pulse: byte dropped, bad stop bit |
| rts_n_o | output | 1 | Active-low ready-to-send |

## Verification
Two events can fall in the same cycle: a frame completing its stop-bit sample, and a read popping storage. The bench starts a frame and counts clock edges from the moment it drives the start bit low. It then raises `rd_ready_i` for exactly the cycle in which the stop bit is sampled.

With one byte queued, both actions must take effect: the newer byte remains and no overrun occurs. With storage at capacity, the new byte must be dropped with an overrun pulse while the read still removes the oldest byte. The bench judges this from the drained byte sequence and the pulse count.

// File: rtl/uart_rx_rts.sv
module uart_rx_rts #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic              rts_en_i,
  input  logic              fifo_mode_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic              rx_not_empty_o,
  output logic              overrun_o,
  output logic              frame_err_o,
  output logic              rts_n_o
);
  localparam int CW = $clog2(OVS);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] HALF   = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] FULLT  = CW'(OVS - 1);
  localparam logic [BW-1:0] LASTB  = BW'(DATA_W - 1);
  localparam logic [PW-1:0] LASTP  = PW'(DEPTH - 1);
  localparam logic [NW-1:0] CAP    = NW'(DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  st_t              st;
  logic [1:0]       sync;
  logic [CW-1:0]    tcnt;
  logic [BW-1:0]    bidx;
  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic [NW-1:0]    cnt;

  wire rx_s      = sync[1];
  wire frame_end = tick_i && (st == S_STOP) && (tcnt == FULLT);
  wire good      = frame_end && rx_s;
  wire bad       = frame_end && !rx_s;
  wire full      = fifo_mode_i ? (cnt == CAP) : (cnt != '0);
  wire push      = good && !full;
  wire pop       = rd_valid_o && rd_ready_i;

  assign rd_valid_o     = (cnt != '0);
  assign rx_not_empty_o = rd_valid_o;
  assign rd_data_o      = mem[rp];
  assign rts_n_o        = rts_en_i && full;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rx_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      tcnt <= '0;
      bidx <= '0;
      sh   <= '0;
    end else if (tick_i) begin
      case (st)
        S_IDLE: if (!rx_s) begin
          st   <= S_START;
          tcnt <= '0;
        end
        S_START: if (tcnt == HALF) begin
          tcnt <= '0;
          bidx <= '0;
          st   <= rx_s ? S_IDLE : S_DATA;
        end else tcnt <= tcnt + 1'b1;
        S_DATA: if (tcnt == FULLT) begin
          tcnt <= '0;
          sh   <= {rx_s, sh[DATA_W-1:1]};
          if (bidx == LASTB) st <= S_STOP;
          else               bidx <= bidx + 1'b1;
        end else tcnt <= tcnt + 1'b1;
        default: if (tcnt == FULLT) begin
          tcnt <= '0;
          st   <= S_IDLE;
        end else tcnt <= tcnt + 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overrun_o   <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      overrun_o   <= good && full;
      frame_err_o <= bad;
    end
  end

  always_ff @(posedge clk) if (push) mem[wp] <= sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == LASTP) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LASTP) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  p_rts_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rts_n_o |-> rts_en_i);
  p_single_rts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode_i && rts_n_o) |-> rx_not_empty_o);
  p_fifo_rts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode_i && rts_n_o) |-> (cnt == CAP));
  p_last_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && cnt == NW'(1)) |=> !rd_valid_o);
  p_drop_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_o && !$past(pop)) |-> (cnt == $past(cnt)));
  p_ferr_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err_o && !$past(pop)) |-> (cnt == $past(cnt)));
  p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_err_o && overrun_o));
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CAP);
endmodule

// File: tb/test_uart_rx_rts.sv
module test_uart_rx_rts;
  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1, rts_en = 1'b1, fmode = 1'b0, rdy = 1'b0;
  logic [7:0] rdata;
  logic valid, nempty, ovr, ferr, rts_n;
  int n_chk = 0, n_fail = 0, ovr_cnt = 0, ferr_cnt = 0;

  always #2 clk = ~clk;

  uart_rx_rts i_uart_rx_rts (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick_i(1'b1), .rts_en_i(rts_en),
    .fifo_mode_i(fmode), .rd_data_o(rdata), .rd_valid_o(valid), .rd_ready_i(rdy),
    .rx_not_empty_o(nempty), .overrun_o(ovr), .frame_err_o(ferr), .rts_n_o(rts_n));

  always @(negedge clk) begin
    if (ovr) ovr_cnt++;
    if (ferr) ferr_cnt++;
  end

  typedef struct packed { logic [7:0] d; logic stop; } vec_t;
  localparam vec_t VEC [6] = '{'{8'h55, 1'b1}, '{8'hA3, 1'b1}, '{8'h00, 1'b1},
                               '{8'hFF, 1'b1}, '{8'h3C, 1'b0}, '{8'h81, 1'b1}};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic stp);
    @(posedge clk); #1 rx = 1'b0;
    for (int i = 0; i < 8; i++) begin
      repeat (16) @(posedge clk); #1 rx = b[i];
    end
    repeat (16) @(posedge clk); #1 rx = stp;
    repeat (16) @(posedge clk); #1 rx = 1'b1;
    repeat (24) @(posedge clk);
  endtask

  task automatic take(output logic [7:0] d);
    @(negedge clk); d = rdata;
    @(posedge clk); #1 rdy = 1'b1;
    @(posedge clk); #1 rdy = 1'b0;
  endtask

  task automatic send_pop_at_stop(input logic [7:0] b);
    fork
      send(b, 1'b1);
      begin
        repeat (155) @(posedge clk);
        #1 rdy = 1'b1;
        @(posedge clk); #1 rdy = 1'b0;
      end
    join
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int o0, f0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R11 valid", valid, 0); chk("R11 not_empty", nempty, 0);
    chk("R11 rts_n", rts_n, 0); chk("R11 overrun", ovr, 0); chk("R11 ferr", ferr, 0);

    // R6 R9 R3 R2: table in single-register mode
    foreach (VEC[k]) begin
      f0 = ferr_cnt;
      send(VEC[k].d, VEC[k].stop);
      @(negedge clk);
      chk("R6 R9 stored", valid, VEC[k].stop);
      chk("R9 ferr pulses", ferr_cnt - f0, VEC[k].stop ? 0 : 1);
      chk("R3 rts_n", rts_n, VEC[k].stop);
      if (VEC[k].stop) begin
        chk("R6 data", rdata, VEC[k].d);
        take(d);
        @(negedge clk);
        chk("R5 empty", nempty, 0); chk("R2 R5 rts_n low", rts_n, 0);
      end
    end

    // R6 glitch
    f0 = ferr_cnt;
    @(posedge clk); #1 rx = 1'b0;
    repeat (5) @(posedge clk); #1 rx = 1'b1;
    repeat (200) @(posedge clk); @(negedge clk);
    chk("R6 glitch no byte", valid, 0); chk("R6 glitch no ferr", ferr_cnt - f0, 0);

    // R1 and R7
    rts_en = 1'b0;
    send(8'h12, 1'b1);
    @(negedge clk); chk("R1 rts_n low held", rts_n, 0);
    fork
      send(8'h34, 1'b1);
      begin
        repeat (80) @(posedge clk); #1 rts_en = 1'b1;
        @(negedge clk); chk("R7 rts_n high mid frame", rts_n, 1);
        take(d); chk("R7 first byte", d, 8'h12);
        @(negedge clk); chk("R5 rts_n low after read", rts_n, 0);
      end
    join
    @(negedge clk);
    chk("R7 frame kept", valid, 1); chk("R7 data", rdata, 8'h34);
    take(d);

    // R4 R8 R10 queue mode
    fmode = 1'b1;
    for (int i = 0; i < 4; i++) begin
      send(8'hA0 + 8'(i), 1'b1);
      @(negedge clk);
      chk("R4 rts_n by fill", rts_n, (i == 3) ? 1 : 0);
    end
    o0 = ovr_cnt;
    send(8'hEE, 1'b1);
    @(negedge clk);
    chk("R8 overrun pulse", ovr_cnt - o0, 1); chk("R4 still full", rts_n, 1);
    o0 = ovr_cnt;
    send_pop_at_stop(8'hDD);
    @(negedge clk);
    chk("R8 R10 full plus read drops", ovr_cnt - o0, 1);
    chk("R5 rts_n low after read", rts_n, 0);
    for (int i = 1; i < 4; i++) begin
      @(negedge clk); chk("R10 order", rdata, 8'hA0 + i);
      take(d);
    end
    @(negedge clk);
    chk("R5 drained", valid, 0);

    o0 = ovr_cnt;
    send(8'h5A, 1'b1);
    send_pop_at_stop(8'hC3);
    @(negedge clk);
    chk("R10 simultaneous no overrun", ovr_cnt - o0, 0);
    chk("R10 one held", valid, 1); chk("R10 newer byte", rdata, 8'hC3);
    take(d);
    @(negedge clk);
    chk("R10 empty after", valid, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule